// File: doc/BRIEF.md
# Burst Idle Green-Mode Controller

This block watches the switching events of a synchronous rectifier channel pair and decides when the rectifier should drop into a low-power standby (green) mode. Each pulse on its event input marks one switching edge of the drain-sense high detector. When the converter goes quiet for a long time, as it does between the bundles of a deep burst mode, the block starts an entry sequence. That sequence is an idle timeout followed by a separate debounce window. Only after both have passed without any edge does it assert the green flag.

While green, the block withdraws the enable it gives to the gate drive logic. That single enable gates switching of both rectifier gates and the adaptive offset current sources. The block leaves green mode when the bursts become dense again, in one of two ways. The first is a single pause between bursts that is short. The second is a run of consecutive switching cycles whose periods all fall within the normal-switching limit. All time constants are parameters counted in system clock cycles.

The interval of an event is the number of clock cycles since the previous event. After reset, the deassertion of reset stands in for that previous event. The interval saturates at IDLE_CYC+DBNC_CYC+1.

Top module: `idle_green_ctrl`

## Requirements
- R1: After reset, `green_o` is 0 and `gate_en_o` is 1.
- R2: With no event since the last event (or since reset), `green_o` rises after exactly IDLE_CYC+DBNC_CYC clock cycles and not one cycle earlier.
- R3: An event during the debounce window aborts entry. A fresh IDLE_CYC+DBNC_CYC quiet cycles, counted from that event, are then needed before `green_o` rises.
- R4: While events keep arriving with intervals shorter than IDLE_CYC, `green_o` stays 0.
- R5: In green mode, an event whose interval is greater than NORM_CYC and less than EXIT_GAP_CYC clears `green_o` on the clock edge that samples it.
- R6: In green mode, an event whose interval is EXIT_GAP_CYC or longer leaves `green_o` at 1. This includes the first event after entry.
- R7: In green mode, a cycle counts as normal when its interval is at most NORM_CYC. The event that completes EXIT_RUNS consecutive normal cycles clears `green_o`, while EXIT_RUNS-1 of them do not.
- R8: An interval longer than NORM_CYC resets the consecutive-cycle count to zero, so a later exit needs a full EXIT_RUNS fresh normal cycles.
- R9: `gate_en_o` is always the inverse of `green_o`, so gate switching and offset currents are disabled exactly while in green mode.
- R10: Without an event, `green_o` never falls. `green_o` falls only on a clock edge that samples an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_evt | input | 1 | One-cycle pulse per switching edge of the drain-sense high flag |
| green_o | output | 1 | Registered green (standby) mode flag |
| gate_en_o | output | 1 | Registered enable for both gate drivers and the offset current sources |

## Verification
The hardest situation to reach is a standby exit through the cycle-count path. The gap-exit window must not fire first, and every burst begins with a long interval that does not count as a normal cycle. The stimulus therefore enters green mode and sends a first event, which must not exit. It then spaces later events exactly NORM_CYC apart, which is below the gap window, and observes that only the completing event clears the flag. Breaking the run with an interval at or above EXIT_GAP_CYC shows the count restarting without a gap exit.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DBNC  = 2'd1,
    ST_GREEN = 2'd2
  } gm_state_t;
endpackage

// File: rtl/gm_gap_timer.sv
// Counts clock cycles since the last switching event (reset counts as one).
module gm_gap_timer #(
  parameter int LIMIT = 240,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_i,
  output logic [CW-1:0] span_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || evt_i) begin
      cnt <= '0;
    end else if (cnt != CW'(LIMIT)) begin
      cnt <= cnt + CW'(1);
    end
  end

  // interval of an event sampled in this cycle
  assign span_o = cnt + CW'(1);
endmodule

// File: rtl/gm_run_counter.sv
// Tracks consecutive normal-period switching cycles.
module gm_run_counter #(
  parameter int NORM_CYC  = 20,
  parameter int EXIT_RUNS = 7,
  parameter int CW        = 8,
  parameter int RW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_i,
  input  logic [CW-1:0] span_i,
  output logic          hit_o
);
  logic [RW-1:0] run;
  logic          normal;

  assign normal = (span_i <= CW'(NORM_CYC));
  assign hit_o  = evt_i && normal && (run == RW'(EXIT_RUNS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (evt_i) begin
      if (!normal) begin
        run <= '0;
      end else if (run != RW'(EXIT_RUNS)) begin
        run <= run + RW'(1);
      end
    end
  end
endmodule

// File: rtl/idle_green_ctrl.sv
module idle_green_ctrl #(
  parameter int IDLE_CYC     = 80,
  parameter int DBNC_CYC     = 160,
  parameter int EXIT_GAP_CYC = 40,
  parameter int NORM_CYC     = 20,
  parameter int EXIT_RUNS    = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_evt,
  output logic green_o,
  output logic gate_en_o
);
  import gm_pkg::*;

  localparam int LIM = IDLE_CYC + DBNC_CYC;
  localparam int CW  = $clog2(LIM + 2);
  localparam int RW  = $clog2(EXIT_RUNS + 1);

  logic [CW-1:0] span;
  logic          run_hit;
  logic          gap_exit;
  gm_state_t     state, nxt;

  gm_gap_timer #(.LIMIT(LIM), .CW(CW)) gap_i (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (sw_evt),
    .span_o (span)
  );

  gm_run_counter #(.NORM_CYC(NORM_CYC), .EXIT_RUNS(EXIT_RUNS), .CW(CW), .RW(RW)) runs_i (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (sw_evt),
    .span_i (span),
    .hit_o  (run_hit)
  );

  assign gap_exit = sw_evt && (span > CW'(NORM_CYC)) && (span < CW'(EXIT_GAP_CYC));

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:   if (!sw_evt && span >= CW'(IDLE_CYC)) nxt = ST_DBNC;
      ST_DBNC:  if (sw_evt) nxt = ST_RUN;
                else if (span >= CW'(LIM)) nxt = ST_GREEN;
      ST_GREEN: if (gap_exit || run_hit) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      green_o   <= 1'b0;
      gate_en_o <= 1'b1;
    end else begin
      state     <= nxt;
      green_o   <= (nxt == ST_GREEN);
      gate_en_o <= (nxt != ST_GREEN);
    end
  end
endmodule

// File: rtl/gm_checker.sv
module gm_checker #(
  parameter int IDLE_CYC     = 80,
  parameter int DBNC_CYC     = 160,
  parameter int EXIT_GAP_CYC = 40,
  parameter int NORM_CYC     = 20,
  parameter int EXIT_RUNS    = 7
) (
  input logic clk,
  input logic rst,
  input logic sw_evt,
  input logic green_o,
  input logic gate_en_o
);
  localparam int LIM = IDLE_CYC + DBNC_CYC;
  localparam int CW  = $clog2(LIM + 2);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst || sw_evt) quiet <= '0;
    else if (quiet != CW'(LIM)) quiet <= quiet + CW'(1);
  end

  // R9
  enable_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    gate_en_o != green_o);

  // R2
  entry_on_time_chk: assert property (@(posedge clk) disable iff (rst)
    (!green_o && !sw_evt && quiet == CW'(LIM - 1)) |=> green_o);

  // R2
  entry_not_early_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(green_o) |-> ($past(quiet) == CW'(LIM - 1)));

  // R10
  exit_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(green_o) |-> $past(sw_evt));

  // R10
  green_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (green_o && !sw_evt) |=> green_o);
endmodule

bind idle_green_ctrl gm_checker #(
  .IDLE_CYC(IDLE_CYC), .DBNC_CYC(DBNC_CYC), .EXIT_GAP_CYC(EXIT_GAP_CYC),
  .NORM_CYC(NORM_CYC), .EXIT_RUNS(EXIT_RUNS)
) chk_i (
  .clk(clk), .rst(rst), .sw_evt(sw_evt), .green_o(green_o), .gate_en_o(gate_en_o)
);

// File: tb/idle_green_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_green_ctrl_tb_top;
  localparam int IDLE = 80;
  localparam int DBNC = 160;
  localparam int GAP  = 40;
  localparam int NORM = 20;
  localparam int RUNS = 7;
  localparam int LIM  = IDLE + DBNC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_evt = 1'b0;
  logic green_o, gate_en_o;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  idle_green_ctrl #(.IDLE_CYC(IDLE), .DBNC_CYC(DBNC), .EXIT_GAP_CYC(GAP),
                    .NORM_CYC(NORM), .EXIT_RUNS(RUNS)) dut_i (
    .clk(clk), .rst(rst), .sw_evt(sw_evt), .green_o(green_o), .gate_en_o(gate_en_o)
  );

  task automatic chk(input string req, input logic exp_green);
    n_chk++;
    if (green_o !== exp_green || gate_en_o !== !exp_green) begin
      n_bad++;
      $display("FAIL %s: green=%b gate_en=%b expected green=%b gate_en=%b",
               req, green_o, gate_en_o, exp_green, !exp_green);
    end
  endtask

  // one posedge with sw_evt = e; outputs sampled at the following negedge
  task automatic step(input logic e);
    sw_evt = e;
    @(negedge clk);
    sw_evt = 1'b0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  // event whose interval from the previous event is n cycles
  task automatic evt_after(input int n);
    quiet(n - 1);
    step(1'b1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    quiet(3);
    rst = 1'b0;
  endtask

  task automatic enter_green();
    step(1'b1);
    quiet(LIM);
  endtask

  task automatic t_reset_and_entry();
    do_reset();
    chk("R1 reset state", 1'b0);
    quiet(LIM - 1);
    chk("R2 one cycle before entry", 1'b0);
    step(1'b0);
    chk("R2 entry after idle plus debounce", 1'b1);
  endtask

  task automatic t_debounce_cancel();
    do_reset();
    step(1'b1);
    quiet(IDLE + 50);
    chk("R3 in debounce window", 1'b0);
    step(1'b1);
    quiet(LIM - 1);
    chk("R3 restarted entry not yet done", 1'b0);
    step(1'b0);
    chk("R3 entry after full restart", 1'b1);
  endtask

  task automatic t_busy_stays_active();
    do_reset();
    for (int i = 0; i < 30; i++) evt_after(IDLE - 1);
    chk("R4 dense events stay active", 1'b0);
  endtask

  task automatic t_gap_exit();
    do_reset();
    enter_green();
    step(1'b1);
    chk("R6 first burst event keeps green", 1'b1);
    evt_after(GAP);
    chk("R6 interval equal to exit gap keeps green", 1'b1);
    evt_after(GAP - 1);
    chk("R5 short gap exits", 1'b0);
    enter_green();
    step(1'b1);
    evt_after(NORM + 1);
    chk("R5 gap just above normal exits", 1'b0);
  endtask

  task automatic t_run_exit();
    do_reset();
    enter_green();
    step(1'b1);
    for (int i = 0; i < RUNS - 1; i++) evt_after(NORM);
    chk("R7 one run short keeps green", 1'b1);
    evt_after(NORM);
    chk("R7 full run exits", 1'b0);
  endtask

  task automatic t_run_reset();
    do_reset();
    enter_green();
    step(1'b1);
    for (int i = 0; i < 4; i++) evt_after(NORM);
    evt_after(GAP + 10);
    chk("R8 long interval does not exit", 1'b1);
    for (int i = 0; i < RUNS - 1; i++) evt_after(NORM);
    chk("R8 count restarted keeps green", 1'b1);
    evt_after(NORM);
    chk("R8 fresh full run exits", 1'b0);
    quiet(5);
    chk("R9 enable back after exit", 1'b0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset_and_entry();
        t_debounce_cancel();
        t_busy_stays_active();
        t_gap_exit();
        t_run_exit();
        t_run_reset();
        done = 1'b1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog: run did not finish, expected completion");
        end
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule